// File: doc/BRIEF.md
# HDLC Transmit FIFO with Ready and Underrun Interrupts

This block is the byte store that sits between a host and the bit-level side of a packet-oriented (HDLC-style) transmitter. The host writes one byte per cycle, each byte carrying an end-of-message marker. A downstream serializer reads bytes in show-ahead fashion: the head byte and its marker are always on the output, and a pop strobe consumes it. The FIFO holds 128 bytes by default.

Two conditions are reported to the host. The first is a ready condition: the fill level is below a low-water mark picked by a 2-bit select, so more bytes can be written. The second is an underrun: the FIFO ran dry right after a byte that did not close a message, so the packet on the line is broken. Each condition has a sticky indication bit, cleared by a write-one pulse, and an enable bit. A registered interrupt line combines the enabled indications. A rising edge on a transmitter-reset control bit clears the FIFO and both indications.

Top module: `htx_fifo_irq`

## Requirements
- R1: Bytes leave in the order they were written, each with its own end-of-message marker. `headData`/`headEom` show the oldest stored byte while the FIFO is not empty, and `popEn` consumes it at the clock edge.
- R2: `level` gives the number of stored bytes. `empty` is high when `level` is 0 and `full` is high when `level` equals the depth (128).
- R3: A write while full is dropped and leaves the stored bytes and `level` unchanged. A pop while empty does not move the FIFO, and while the FIFO is empty `headData` shows the idle byte 0x7E with `headEom` low.
- R4: `rdyStat` is high whenever `level` is below the low-water mark. `lowSel` values 0, 1, 2 and 3 select marks of 16, 32, 64 and 96 bytes.
- R5: `rdyInd` is set at the clock edge after `rdyStat` goes from 0 to 1. It is not set again while `rdyStat` stays high. Leaving reset or a transmitter reset does not set it.
- R6: `udrInd` is set at the edge of a pop that empties the FIFO when the popped byte has its end-of-message marker low. A pop of a byte with the marker high does not set it.
- R7: Both indications are sticky. A one-cycle pulse on `clrRdy` or `clrUdr` clears its indication at the next edge. If the set condition occurs in the same cycle, the set wins.
- R8: `irq` equals (`rdyInd` AND `rdyEn`) OR (`udrInd` AND `udrEn`), delayed by one clock.
- R9: A 0-to-1 transition of `txRst` empties the FIFO and clears both indications at the next edge. Holding `txRst` high has no further effect, so writes are accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Host write strobe |
| wrData | input | 8 | Byte to store |
| wrEom | input | 1 | End-of-message marker of the written byte |
| popEn | input | 1 | Serializer pop strobe |
| headData | output | 8 | Head byte, or 0x7E when empty |
| headEom | output | 1 | End-of-message marker of the head byte |
| lowSel | input | 2 | Low-water mark select |
| rdyEn | input | 1 | Ready interrupt enable |
| udrEn | input | 1 | Underrun interrupt enable |
| clrRdy | input | 1 | Write-one clear of the ready indication |
| clrUdr | input | 1 | Write-one clear of the underrun indication |
| txRst | input | 1 | Transmitter reset control, acts on rising edge |
| level | output | 8 | Stored byte count |
| empty | output | 1 | FIFO empty |
| full | output | 1 | FIFO full |
| rdyStat | output | 1 | Level below low-water mark |
| rdyInd | output | 1 | Sticky ready indication |
| udrInd | output | 1 | Sticky underrun indication |
| irq | output | 1 | Registered interrupt |

## Verification
`level`, `empty`, `full` and the head byte change at the edge that takes a write or pop. `rdyStat` follows `level` and `lowSel` with no delay. `rdyInd` follows one edge after `rdyStat` rises and `udrInd` at the same edge as the emptying pop. `irq` comes one edge after the indication or enable that drives it. The bench drives inputs on the falling edge and checks on the following falling edge, so each check sees exactly one rising edge. For `rdyInd` and `irq` it checks once before the extra cycle, where the old value is expected, and once after, where the new value is expected.

// File: rtl/htx_pkg.sv
package htx_pkg;
  // strobes the control side issues to the storage side
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } htxStrobeT;
endpackage

// File: rtl/htx_fifo_dp.sv
module htx_fifo_dp
  import htx_pkg::*;
#(
  parameter int DEPTH     = 128,
  parameter int DATA_W    = 8,
  parameter logic [DATA_W-1:0] IDLE_BYTE = 8'h7E,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int CNT_W    = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  htxStrobeT         str,
  input  logic [DATA_W-1:0] inData,
  input  logic              inEom,
  output logic [DATA_W-1:0] headData,
  output logic              headEom,
  output logic [CNT_W-1:0]  level,
  output logic              empty,
  output logic              full
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W:0]   mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  cnt;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (str.push && !str.flush) mem[wrPtr] <= {inEom, inData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else if (str.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (str.push) wrPtr <= nextPtr(wrPtr);
      if (str.pop)  rdPtr <= nextPtr(rdPtr);
      case ({str.push, str.pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign level = cnt;
  assign empty = (cnt == '0);
  assign full  = (cnt == FULL_CNT);

  always_comb begin
    if (empty) begin
      headData = IDLE_BYTE;
      headEom  = 1'b0;
    end else begin
      headData = mem[rdPtr][DATA_W-1:0];
      headEom  = mem[rdPtr][DATA_W];
    end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    str.flush |=> (empty && level == '0)); // R9
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (full && !str.pop && !str.flush) |=> (full && $stable(wrPtr))); // R3
  AST_EMPTY_NO_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    (empty && !str.push && !str.flush) |=> (empty && $stable(rdPtr))); // R3
endmodule

// File: rtl/htx_irq_ctrl.sv
module htx_irq_ctrl
  import htx_pkg::*;
#(
  parameter int DEPTH  = 128,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             popEn,
  input  logic             txRst,
  input  logic [1:0]       lowSel,
  input  logic             rdyEn,
  input  logic             udrEn,
  input  logic             clrRdy,
  input  logic             clrUdr,
  input  logic [CNT_W-1:0] level,
  input  logic             empty,
  input  logic             full,
  input  logic             headEom,
  output htxStrobeT        str,
  output logic             rdyStat,
  output logic             rdyInd,
  output logic             udrInd,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

  // low-water marks as fractions of the depth: 1/8, 1/4, 1/2, 3/4
  logic [CNT_W-1:0] markTab [4];
  for (genvar g = 0; g < 4; g++) begin : gMark
    localparam int NUM = (g == 3) ? 3 : 1;
    localparam int DEN = (g == 0) ? 8 : (g == 1) ? 4 : (g == 2) ? 2 : 4;
    assign markTab[g] = CNT_W'((DEPTH * NUM) / DEN);
  end

  logic txRstPrev, rdyPrev;
  logic rdyRise, udrHit;

  always_comb begin
    str.flush = txRst && !txRstPrev;
    str.push  = wrEn && !full;
    str.pop   = popEn && !empty;
  end

  assign rdyStat = (level < markTab[lowSel]);
  assign rdyRise = rdyStat && !rdyPrev;
  assign udrHit  = str.pop && !str.push && (level == ONE_CNT) && !headEom;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txRstPrev <= 1'b0;
      rdyPrev   <= 1'b1;
      rdyInd    <= 1'b0;
      udrInd    <= 1'b0;
      irq       <= 1'b0;
    end else begin
      txRstPrev <= txRst;
      irq       <= (rdyInd && rdyEn) || (udrInd && udrEn);
      if (str.flush) begin
        rdyPrev <= 1'b1;
        rdyInd  <= 1'b0;
        udrInd  <= 1'b0;
      end else begin
        rdyPrev <= rdyStat;
        if (rdyRise)     rdyInd <= 1'b1;
        else if (clrRdy) rdyInd <= 1'b0;
        if (udrHit)      udrInd <= 1'b1;
        else if (clrUdr) udrInd <= 1'b0;
      end
    end
  end

  logic flushSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flushSeen <= 1'b1;
    else       flushSeen <= str.flush;
  end

  AST_RDY_EDGE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rdyStat) && !str.flush && !flushSeen) |=> rdyInd); // R5
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    ((rdyInd && rdyEn) || (udrInd && udrEn)) |=> irq); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !((rdyInd && rdyEn) || (udrInd && udrEn)) |=> !irq); // R8
  AST_UDR_ON_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !empty && !wrEn && level == ONE_CNT && !headEom && !str.flush) |=> udrInd); // R6
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !str.push); // R3
endmodule

// File: rtl/htx_fifo_irq.sv
module htx_fifo_irq
  import htx_pkg::*;
#(
  parameter int DEPTH  = 128,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  input  logic             wrEom,
  input  logic             popEn,
  output logic [7:0]       headData,
  output logic             headEom,
  input  logic [1:0]       lowSel,
  input  logic             rdyEn,
  input  logic             udrEn,
  input  logic             clrRdy,
  input  logic             clrUdr,
  input  logic             txRst,
  output logic [CNT_W-1:0] level,
  output logic             empty,
  output logic             full,
  output logic             rdyStat,
  output logic             rdyInd,
  output logic             udrInd,
  output logic             irq
);
  htxStrobeT str;

  htx_irq_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .popEn(popEn), .txRst(txRst),
    .lowSel(lowSel), .rdyEn(rdyEn), .udrEn(udrEn), .clrRdy(clrRdy),
    .clrUdr(clrUdr), .level(level), .empty(empty), .full(full),
    .headEom(headEom), .str(str), .rdyStat(rdyStat), .rdyInd(rdyInd),
    .udrInd(udrInd), .irq(irq)
  );

  htx_fifo_dp #(.DEPTH(DEPTH), .DATA_W(8), .IDLE_BYTE(8'h7E)) uData (
    .clk(clk), .rstN(rstN), .str(str), .inData(wrData), .inEom(wrEom),
    .headData(headData), .headEom(headEom), .level(level),
    .empty(empty), .full(full)
  );
endmodule

// File: tb/tb_htx_fifo_irq.sv
module tb_htx_fifo_irq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 0, wrEom = 0, popEn = 0, rdyEn = 0, udrEn = 0;
  logic clrRdy = 0, clrUdr = 0, txRst = 0;
  logic [7:0] wrData = '0;
  logic [1:0] lowSel = 2'd0;
  logic [7:0] headData, level;
  logic headEom, empty, full, rdyStat, rdyInd, udrInd, irq;
  int nChk = 0, nBad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  htx_fifo_irq dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .wrEom(wrEom),
    .popEn(popEn), .headData(headData), .headEom(headEom), .lowSel(lowSel),
    .rdyEn(rdyEn), .udrEn(udrEn), .clrRdy(clrRdy), .clrUdr(clrUdr),
    .txRst(txRst), .level(level), .empty(empty), .full(full),
    .rdyStat(rdyStat), .rdyInd(rdyInd), .udrInd(udrInd), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(); @(negedge clk); endtask
  task automatic push(input logic [7:0] b, input logic e);
    wrEn = 1; wrData = b; wrEom = e; @(negedge clk); wrEn = 0;
  endtask
  task automatic pop();
    popEn = 1; @(negedge clk); popEn = 0;
  endtask
  task automatic flush();
    txRst = 1; @(negedge clk); txRst = 0; @(negedge clk);
  endtask

  task automatic tReset();
    chk("R2 empty after reset", empty, 1);
    chk("R2 full after reset", full, 0);
    chk("R2 level after reset", level, 0);
    chk("R3 idle head", headData, 8'h7E);
    chk("R5 no rdyInd after reset", rdyInd, 0);
    chk("R6 no udrInd after reset", udrInd, 0);
    chk("R8 irq after reset", irq, 0);
  endtask

  task automatic tOrder();
    push(8'hA1, 0); push(8'hA2, 0); push(8'hA3, 1);
    chk("R2 level 3", level, 3);
    chk("R1 head A1", headData, 8'hA1);
    chk("R1 eom A1", headEom, 0);
    pop();
    chk("R1 head A2", headData, 8'hA2);
    pop();
    chk("R1 head A3", headData, 8'hA3);
    chk("R1 eom A3", headEom, 1);
    pop();
    chk("R2 empty after drain", empty, 1);
    chk("R6 no underrun on final byte", udrInd, 0);
    chk("R5 no rdyInd while rdy held", rdyInd, 0);
  endtask

  task automatic tUnderrun();
    push(8'hB1, 0); pop();
    chk("R6 underrun set", udrInd, 1);
    idle();
    chk("R8 irq masked", irq, 0);
    udrEn = 1;
    chk("R8 irq not yet", irq, 0);
    idle();
    chk("R8 irq one cycle later", irq, 1);
    clrUdr = 1; @(negedge clk); clrUdr = 0;
    chk("R7 udr cleared", udrInd, 0);
    chk("R8 irq still high", irq, 1);
    idle();
    chk("R8 irq low after clear", irq, 0);
    udrEn = 0;
  endtask

  task automatic tReady();
    lowSel = 2'd0; rdyEn = 0;
    flush();
    for (int i = 0; i < 16; i++) push(8'(i), 1);
    chk("R4 level 16 not below 16", rdyStat, 0);
    pop();
    chk("R4 level 15 below 16", rdyStat, 1);
    chk("R5 rdyInd not before next edge", rdyInd, 0);
    idle();
    chk("R5 rdyInd set", rdyInd, 1);
    chk("R8 rdy irq masked", irq, 0);
    rdyEn = 1; idle();
    chk("R8 rdy irq", irq, 1);
    clrRdy = 1; @(negedge clk); clrRdy = 0;
    idle(); idle();
    chk("R7 rdyInd cleared, no retrigger (R5)", rdyInd, 0);
    chk("R8 irq off", irq, 0);
    rdyEn = 0;
    for (int i = 0; i < 25; i++) push(8'(i), 1);
    chk("R2 level 40", level, 40);
    chk("R4 sel0 16", rdyStat, 0);
    lowSel = 2'd1; #1 chk("R4 sel1 32", rdyStat, 0);
    lowSel = 2'd2; #1 chk("R4 sel2 64", rdyStat, 1);
    lowSel = 2'd3; #1 chk("R4 sel3 96", rdyStat, 1);
    lowSel = 2'd0;
    idle();
  endtask

  task automatic tFull();
    int bad = 0;
    flush();
    for (int i = 0; i < 128; i++) push(8'(i), (i == 127));
    chk("R2 full", full, 1);
    chk("R2 level 128", level, 128);
    push(8'hEE, 0);
    chk("R3 write while full dropped", level, 128);
    for (int i = 0; i < 128; i++) begin
      if (headData != 8'(i)) bad++;
      if (i == 127 && headEom != 1'b1) bad++;
      pop();
    end
    chk("R1 R3 content after drop", bad, 0);
    chk("R6 no underrun on eom byte", udrInd, 0);
    pop();
    chk("R3 pop while empty level", level, 0);
    chk("R3 pop while empty idle", headData, 8'h7E);
    push(8'h5A, 0);
    chk("R3 pointers intact", headData, 8'h5A);
    chk("R2 level 1", level, 1);
  endtask

  task automatic tFlush();
    pop();
    chk("R6 underrun before flush", udrInd, 1);
    push(8'h11, 0); push(8'h12, 0);
    txRst = 1; idle();
    chk("R9 flush empties", empty, 1);
    chk("R9 flush clears udrInd", udrInd, 0);
    chk("R9 flush leaves rdyInd clear", rdyInd, 0);
    push(8'h21, 1); push(8'h22, 1);
    chk("R9 held high no reflush", level, 2);
    chk("R9 head after held", headData, 8'h21);
    txRst = 0; idle();
    txRst = 1; idle(); txRst = 0;
    chk("R9 second edge flushes", level, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    idle();
    tReset();
    tOrder();
    tUnderrun();
    tReady();
    tFull();
    tFlush();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule